// File: doc/BRIEF.md
# In-Place Vector AES-128 Encryption Engine

This block encrypts a run of 128-bit elements held in a vector register group, using the full ten-round AES-128 cipher. Each element is treated as 128 bits, whatever element width is configured elsewhere. The engine reads the plaintext from a destination element. It encrypts it under a key taken from a second register group and writes the ciphertext back over the same destination element. Round keys are expanded on the fly, one round per clock. The cipher key is reloaded at the start of every element.

A caller provides a first-element index, an element count and a key-sharing mode, and pulses `start`. The engine works through the elements in ascending order, from the first index up to the count. In per-element mode, element i uses key-group element i. In shared mode, every element uses key-group element 0. The two register groups are read through combinational index/data ports. Results leave through a valid/ready write port. A write is offered with `wr_valid_o` and completes on the rising edge where `wr_ready_i` is also high. While `wr_ready_i` is low, the engine holds the write and does nothing else. Pulling `wr_ready_i` low therefore stalls the whole run without losing or altering the result. Control and status (`start`, `busy_o`, `done_o`) are plain levels and pulses.

Byte k of a 128-bit element sits in bits [8k+7:8k]. Bytes fill the AES state column by column, so byte k is row k mod 4 of column k div 4.

Top module: `vaes_inplace_enc`

## Requirements
- R1: Plaintext ffeeddccbbaa99887766554433221100 (hex, bits 127..0) under key 0f0e0d0c0b0a09080706050403020100 encrypts to 5ac5b47080b7cdd830047b6ad8e0c469. This is the standard AES-128 example in the byte layout above.
- R2: The ciphertext of an element is written to the same destination index its plaintext was read from. No other index is written for it.
- R3: With `key_shared_i` = 0, element i is encrypted under key-group element i.
- R4: With `key_shared_i` = 1, every element is encrypted under key-group element 0.
- R5: Destination elements below the first index, and those at or above the count, keep their contents.
- R6: Active elements are written exactly once each, in ascending index order.
- R7: If the count is zero or the first index is at or above the count, `done_o` rises in the cycle after `start` is sampled. No write is made and `busy_o` stays low.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_idx_o` and `wr_data_o` hold steady.
- R9: Out of reset, `busy_o`, `done_o` and `wr_valid_o` are low. `done_o` is a one-cycle pulse, never high together with `busy_o`, and it follows the last accepted write by one cycle.
- R10: A `start` pulse that arrives while the engine is busy is ignored.
- R11: With `wr_ready_i` held high, the first write is offered 11 cycles after the cycle that samples `start`. Each element takes 12 cycles, so a run of k elements raises `done_o` 12k+1 rising edges after `start` is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| first_i | input | CNTW | Index of the first element to encrypt |
| count_i | input | CNTW | Element count; elements first_i..count_i-1 are processed |
| key_shared_i | input | 1 | 1: all elements use key element 0; 0: per-element keys |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pt_idx_o | output | IDXW | Destination-group read index |
| pt_data_i | input | 128 | Destination-group read data (plaintext) |
| key_idx_o | output | IDXW | Key-group read index |
| key_data_i | input | 128 | Key-group read data |
| wr_valid_o | output | 1 | Write offered to the destination group |
| wr_ready_i | input | 1 | Destination group accepts the write |
| wr_idx_o | output | IDXW | Write index |
| wr_data_o | output | 128 | Ciphertext to write |

## Verification
The bench targets several corner cases, each tied to a specific kind of mistake:
- **Standard example vector.** Any slip in byte order, ShiftRows direction or the round-constant sequence corrupts this known ciphertext.
- **Shared-key run from a non-zero first index.** A design that ignored the mode would mix keys. One that mishandled the first index would overwrite the protected low elements, and one that mishandled the count would overwrite the protected high elements.
- **Empty runs (count zero, first index at or past the count).** These catch an engine that writes a stray element or hangs.
- **Random write back-pressure.** This catches results that are lost, duplicated or changed while stalled.
- **Stray `start` during a run.** This catches an engine that restarts or corrupts memory.
- **Cycle counts to the first write and to `done_o`.** These catch an extra or missing round, or a missing reload step.

// File: rtl/vaes_pkg.sv
package vaes_pkg;

  localparam int BLKW    = 128;
  localparam int NROUNDS = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RND,
    ST_WR,
    ST_FIN
  } fsm_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // forward S-box: multiplicative inverse as a^254, then the affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] inv;
    logic [7:0] base;
    logic [7:0] exp_bits;
    inv      = 8'h01;
    base     = a;
    exp_bits = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (exp_bits[i]) inv = gf_mul(inv, base);
      base = gf_mul(base, base);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/vaes_sbox.sv
module vaes_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  import vaes_pkg::*;

  assign y_o = sbox_fwd(a_i);

endmodule

// File: rtl/vaes_keystep.sv
// One step of the AES-128 key expansion: next round key from the current one.
module vaes_keystep (
  input  logic [127:0] key_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] key_o
);
  logic [31:0] sub_w;
  logic [31:0] tmp_w;
  logic [31:0] n0, n1, n2, n3;

  // rotate word 3 by one byte, substitute each byte
  for (genvar j = 0; j < 4; j++) begin : g_sub
    vaes_sbox u_sb (
      .a_i (key_i[96 + 8*((j+1)%4) +: 8]),
      .y_o (sub_w[8*j +: 8])
    );
  end

  assign tmp_w = sub_w ^ {24'h0, rcon_i};
  assign n0    = key_i[31:0]   ^ tmp_w;
  assign n1    = key_i[63:32]  ^ n0;
  assign n2    = key_i[95:64]  ^ n1;
  assign n3    = key_i[127:96] ^ n2;
  assign key_o = {n3, n2, n1, n0};

endmodule

// File: rtl/vaes_round.sv
// One forward AES round; last_i drops the column mixing step.
module vaes_round (
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  import vaes_pkg::*;

  logic [127:0] sb;
  logic [127:0] sr;
  logic [127:0] mc;

  for (genvar k = 0; k < 16; k++) begin : g_sbox
    vaes_sbox u_sb (
      .a_i (state_i[8*k +: 8]),
      .y_o (sb[8*k +: 8])
    );
  end

  // row r of column c takes row r of column (c+r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[8*(4*c+r) +: 8] = sb[8*(4*((c+r)%4)+r) +: 8];
    end

    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr[32*c      +: 8];
    assign a1 = sr[32*c + 8  +: 8];
    assign a2 = sr[32*c + 16 +: 8];
    assign a3 = sr[32*c + 24 +: 8];

    assign mc[32*c      +: 8] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mc[32*c + 8  +: 8] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
    assign mc[32*c + 16 +: 8] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
    assign mc[32*c + 24 +: 8] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
  end

  assign state_o = (last_i ? sr : mc) ^ rkey_i;

endmodule

// File: rtl/vaes_inplace_enc.sv
module vaes_inplace_enc #(
  parameter  int NELEM = 8,
  localparam int IDXW  = $clog2(NELEM),
  localparam int CNTW  = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNTW-1:0]  first_i,
  input  logic [CNTW-1:0]  count_i,
  input  logic             key_shared_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDXW-1:0]  pt_idx_o,
  input  logic [127:0]     pt_data_i,
  output logic [IDXW-1:0]  key_idx_o,
  input  logic [127:0]     key_data_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [IDXW-1:0]  wr_idx_o,
  output logic [127:0]     wr_data_o
);
  import vaes_pkg::*;

  localparam int RW = $clog2(NROUNDS + 1);

  fsm_e            fsm_q;
  logic [CNTW-1:0] elem_q;
  logic [CNTW-1:0] end_q;
  logic            shared_q;
  logic [BLKW-1:0] state_q;
  logic [BLKW-1:0] rk_q;
  logic [7:0]      rcon_q;
  logic [RW-1:0]   rnd_q;

  logic [BLKW-1:0] rk_next;
  logic [BLKW-1:0] state_next;
  logic [CNTW-1:0] cnt_eff;
  logic [CNTW-1:0] elem_inc;
  logic            empty_run;
  logic            last_rnd;

  assign cnt_eff   = (count_i > CNTW'(NELEM)) ? CNTW'(NELEM) : count_i;
  assign empty_run = (cnt_eff == '0) || (first_i >= cnt_eff);
  assign elem_inc  = elem_q + CNTW'(1);
  assign last_rnd  = (rnd_q == RW'(NROUNDS));

  vaes_keystep u_keystep (
    .key_i  (rk_q),
    .rcon_i (rcon_q),
    .key_o  (rk_next)
  );

  vaes_round u_round (
    .state_i (state_q),
    .rkey_i  (rk_next),
    .last_i  (last_rnd),
    .state_o (state_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q    <= ST_IDLE;
      elem_q   <= '0;
      end_q    <= '0;
      shared_q <= 1'b0;
      state_q  <= '0;
      rk_q     <= '0;
      rcon_q   <= 8'h01;
      rnd_q    <= '0;
    end else begin
      unique case (fsm_q)
        ST_IDLE: begin
          if (start) begin
            shared_q <= key_shared_i;
            end_q    <= cnt_eff;
            elem_q   <= first_i;
            fsm_q    <= empty_run ? ST_FIN : ST_LOAD;
          end
        end
        ST_LOAD: begin
          state_q <= pt_data_i ^ key_data_i;
          rk_q    <= key_data_i;
          rcon_q  <= 8'h01;
          rnd_q   <= RW'(1);
          fsm_q   <= ST_RND;
        end
        ST_RND: begin
          state_q <= state_next;
          rk_q    <= rk_next;
          rcon_q  <= gf_xtime(rcon_q);
          rnd_q   <= rnd_q + RW'(1);
          if (last_rnd) fsm_q <= ST_WR;
        end
        ST_WR: begin
          if (wr_ready_i) begin
            elem_q <= elem_inc;
            fsm_q  <= (elem_inc >= end_q) ? ST_FIN : ST_LOAD;
          end
        end
        ST_FIN: begin
          fsm_q <= ST_IDLE;
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (fsm_q == ST_LOAD) || (fsm_q == ST_RND) || (fsm_q == ST_WR);
  assign done_o     = (fsm_q == ST_FIN);
  assign pt_idx_o   = elem_q[IDXW-1:0];
  assign key_idx_o  = shared_q ? '0 : elem_q[IDXW-1:0];
  assign wr_valid_o = (fsm_q == ST_WR);
  assign wr_idx_o   = elem_q[IDXW-1:0];
  assign wr_data_o  = state_q;

endmodule

// File: rtl/vaes_inplace_enc_chk.sv
module vaes_inplace_enc_chk #(
  parameter  int NELEM = 8,
  localparam int IDXW  = $clog2(NELEM)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy_o,
  input logic            done_o,
  input logic            wr_valid_o,
  input logic            wr_ready_i,
  input logic [IDXW-1:0] wr_idx_o,
  input logic [127:0]    wr_data_o
);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_idx_o) && $stable(wr_data_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o)); // R9

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i |=> !wr_valid_o); // R6

  AST_WR_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o); // R2

  AST_RUN_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start)); // R10

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && !$past(busy_o) |-> $past(start)); // R7

endmodule

bind vaes_inplace_enc vaes_inplace_enc_chk #(.NELEM(NELEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_idx_o   (wr_idx_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/vaes_inplace_enc_bench.sv
module vaes_inplace_enc_bench;

  localparam int NELEM = 8;
  localparam int IDXW  = 3;
  localparam int CNTW  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNTW-1:0]  first_i = '0;
  logic [CNTW-1:0]  count_i = '0;
  logic             key_shared_i = 1'b0;
  logic             busy_o, done_o, wr_valid_o;
  logic             wr_ready_i = 1'b1;
  logic [IDXW-1:0]  pt_idx_o, key_idx_o, wr_idx_o;
  logic [127:0]     pt_data_i, key_data_i, wr_data_o;

  logic [127:0] st_mem  [NELEM];
  logic [127:0] key_mem [NELEM];
  logic [127:0] gold    [NELEM];
  logic [7:0]   sbox_t  [256];

  logic [IDXW-1:0] q_idx [$];
  logic [127:0]    q_dat [$];
  string           cur_req = "R3";

  int  n_chk = 0;
  int  n_bad = 0;
  bit  stall_en = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  always #4 clk = ~clk;

  vaes_inplace_enc #(.NELEM(NELEM)) u_vaes_inplace_enc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .first_i      (first_i),
    .count_i      (count_i),
    .key_shared_i (key_shared_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pt_idx_o     (pt_idx_o),
    .pt_data_i    (pt_data_i),
    .key_idx_o    (key_idx_o),
    .key_data_i   (key_data_i),
    .wr_valid_o   (wr_valid_o),
    .wr_ready_i   (wr_ready_i),
    .wr_idx_o     (wr_idx_o),
    .wr_data_o    (wr_data_o)
  );

  assign pt_data_i  = st_mem[pt_idx_o];
  assign key_data_i = key_mem[key_idx_o];

  always @(posedge clk)
    if (wr_valid_o && wr_ready_i) st_mem[wr_idx_o] <= wr_data_o;

  // back-pressure generator
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready_i = stall_en ? lfsr[0] : 1'b1;
  end

  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each accepted write, and stall stability
  logic            hold_pend = 1'b0;
  logic [IDXW-1:0] hold_idx;
  logic [127:0]    hold_dat;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk_int("R8 valid held", int'(wr_valid_o), 1);
        chk_int("R8 index held", int'(wr_idx_o), int'(hold_idx));
        chk128("R8 data held", wr_data_o, hold_dat);
      end
      hold_pend = wr_valid_o && !wr_ready_i;
      hold_idx  = wr_idx_o;
      hold_dat  = wr_data_o;
      if (wr_valid_o && wr_ready_i) begin
        if (q_idx.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R6 unexpected write: actual idx %0d expected none", wr_idx_o);
        end else begin
          chk_int("R2 write index", int'(wr_idx_o), int'(q_idx.pop_front()));
          chk128(cur_req, wr_data_o, q_dat.pop_front());
        end
      end
    end
  end

  function automatic logic [7:0] rl8(input logic [7:0] v, input int s);
    return (v << s) | (v >> (8 - s));
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01;
    q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sbox_t[p] = q ^ rl8(q, 1) ^ rl8(q, 2) ^ rl8(q, 3) ^ rl8(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sbox_t[0] = 8'h63;
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [176];
    logic [7:0] tmp [4];
    logic [7:0] rc;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      w[i] = key[8*i +: 8];
      s[i] = pt[8*i +: 8] ^ key[8*i +: 8];
    end
    for (int i = 16; i < 176; i += 4) begin
      for (int k = 0; k < 4; k++) tmp[k] = w[i-4+k];
      if (i % 16 == 0) begin
        logic [7:0] f;
        f = tmp[0];
        tmp[0] = sbox_t[tmp[1]] ^ rc;
        tmp[1] = sbox_t[tmp[2]];
        tmp[2] = sbox_t[tmp[3]];
        tmp[3] = sbox_t[f];
        rc = xt(rc);
      end
      for (int k = 0; k < 4; k++) w[i+k] = w[i-16+k] ^ tmp[k];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sbox_t[s[i]];
      for (int c = 0; c < 4; c++)
        for (int rr = 0; rr < 4; rr++) t[4*c+rr] = s[4*((c+rr)%4)+rr];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = xt(t[4*c]) ^ xt(t[4*c+1]) ^ t[4*c+1] ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ xt(t[4*c+1]) ^ xt(t[4*c+2]) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ xt(t[4*c+2]) ^ xt(t[4*c+3]) ^ t[4*c+3];
          s[4*c+3] = xt(t[4*c]) ^ t[4*c] ^ t[4*c+1] ^ t[4*c+2] ^ xt(t[4*c+3]);
        end else begin
          for (int k = 0; k < 4; k++) s[4*c+k] = t[4*c+k];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*r+i];
    end
    for (int i = 0; i < 16; i++) res[8*i +: 8] = s[i];
    return res;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < NELEM; i++) begin
      st_mem[i]  = {$urandom, $urandom, $urandom, $urandom};
      key_mem[i] = {$urandom, $urandom, $urandom, $urandom};
      gold[i]    = st_mem[i];
    end
  endtask

  // driver: queue expectations, launch, wait for done, measure latencies
  task automatic run(input int first, input int count, input bit shared,
                     input string req, input bit poke,
                     output int lat_wr, output int lat_done);
    int n;
    cur_req = req;
    for (int i = first; i < count; i++) begin
      logic [127:0] ct;
      ct = ref_enc(st_mem[i], key_mem[shared ? 0 : i]);
      q_idx.push_back(IDXW'(i));
      q_dat.push_back(ct);
      gold[i] = ct;
    end
    @(posedge clk); #2;
    first_i      = CNTW'(first);
    count_i      = CNTW'(count);
    key_shared_i = shared;
    start        = 1'b1;
    n = 0;
    lat_wr = -1;
    lat_done = -1;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      #2;
      start = 1'b0;
      if (poke && n == 5) begin
        first_i = '0;
        count_i = CNTW'(NELEM);
        key_shared_i = ~shared;
        start = 1'b1;
      end
      @(negedge clk);
      if (wr_valid_o && lat_wr < 0) lat_wr = n;
      if (done_o) begin
        lat_done = n;
        break;
      end
    end
    if (lat_done < 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 run never finished: actual no done expected done");
    end
    @(negedge clk);
    chk_int("R9 done one cycle", int'(done_o), 0);
    chk_int("R9 idle after done", int'(busy_o), 0);
    chk_int("R6 all elements written", q_idx.size(), 0);
    for (int i = 0; i < NELEM; i++) chk128("R5 memory contents", st_mem[i], gold[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lw, ld;
    build_sbox();
    fill_random();
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk_int("R9 reset busy", int'(busy_o), 0);
    chk_int("R9 reset done", int'(done_o), 0);
    chk_int("R9 reset wr_valid", int'(wr_valid_o), 0);

    // R1: standard example vector at element 0
    st_mem[0]  = 128'hffeeddccbbaa99887766554433221100;
    key_mem[0] = 128'h0f0e0d0c0b0a09080706050403020100;
    gold[0]    = st_mem[0];
    run(0, 1, 1'b0, "R1", 1'b0, lw, ld);
    chk128("R1 example ciphertext", st_mem[0], 128'h5ac5b47080b7cdd830047b6ad8e0c469);
    chk_int("R11 first write latency", lw, 12);
    chk_int("R11 single-element done latency", ld, 13);

    // R3: per-element keys, four elements, no stalls
    fill_random();
    run(0, 4, 1'b0, "R3", 1'b0, lw, ld);
    chk_int("R11 four-element done latency", ld, 49);

    // R4 and R5: shared key, window 2..6 of 8
    fill_random();
    run(2, 6, 1'b1, "R4", 1'b0, lw, ld);

    // R8: per-element keys under random back-pressure
    fill_random();
    stall_en = 1'b1;
    run(1, 8, 1'b0, "R3", 1'b0, lw, ld);
    run(0, 3, 1'b1, "R4", 1'b0, lw, ld);
    stall_en = 1'b0;

    // R7: empty runs
    run(0, 0, 1'b0, "R7", 1'b0, lw, ld);
    chk_int("R7 count zero done", ld, 1);
    chk_int("R7 count zero no write", lw, -1);
    run(5, 5, 1'b1, "R7", 1'b0, lw, ld);
    chk_int("R7 first equals count done", ld, 1);
    chk_int("R7 first equals count no write", lw, -1);
    run(6, 3, 1'b0, "R7", 1'b0, lw, ld);
    chk_int("R7 first above count done", ld, 1);

    // R10: second start while busy must not add writes
    fill_random();
    run(3, 5, 1'b0, "R10", 1'b1, lw, ld);
    chk_int("R10 run length unchanged", ld, 25);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule